// File: doc/BRIEF.md
# Shader Program Sequencer with Return Stack

This block is the control-flow front end of a small shader processor. It keeps a program store of 32-bit instruction words, written through a simple address/data port. After a start pulse it walks the program from a chosen entry word, presenting one instruction word and its address per cycle to a downstream datapath. Two opcodes change the flow. A subroutine call records its own address on a fixed-depth return stack and jumps. A return resumes at the word after the recorded address.

Every free stack slot holds an all-ones marker. A return that finds the marker on top of the stack has no pending call, so the program ends there and the block raises `done`. It does not underflow. A call that would need a ninth slot raises a sticky error and halts fetching. Every other opcode, including the flush opcode, is passed through to the datapath and only advances the fetch address.

Top module: `shader_seq`

## Requirements
- R1: A cycle with `start` high loads the fetch address from `entry_pc`, empties the return stack, clears `done` and starts fetching: `instr_valid` is high in the next cycle with `fetch_addr` equal to the entry.
- R2: While fetching, an instruction whose opcode (bits [31:26]) is neither call (6'h24) nor return (6'h25) moves the fetch address to the next word. Address 1023 wraps to 0.
- R3: A call (opcode 6'h24) pushes its own address and moves the fetch address to the low 10 bits of the instruction word. Target bits [11:10] and bits [25:12] have no effect.
- R4: A return (opcode 6'h25) with a pending call pops the newest entry and moves the fetch address to that entry plus one. Nested calls unwind newest first.
- R5: A return with no pending call ends the program: in the next cycle `done` is high and `instr_valid` is low. `done` stays high until the next `start`.
- R6: The flush opcode (6'h23) is a no-op and advances the fetch address by one.
- R7: A call made while 8 calls are pending sets `stack_err`, which stays set until reset. Fetching stops in the next cycle and `done` stays low.
- R8: A program-store write (`wr_en`, `wr_addr`, `wr_data`) is visible on `instr_word` whenever that address is fetched afterwards.
- R9: After reset, `instr_valid`, `done` and `stack_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a program run at `entry_pc` |
| entry_pc | input | 10 | Entry word address |
| wr_en | input | 1 | Program store write enable |
| wr_addr | input | 10 | Program store write address |
| wr_data | input | 32 | Program store write data |
| fetch_addr | output | 10 | Address of the word being executed |
| instr_word | output | 32 | Instruction word sent to the datapath |
| instr_valid | output | 1 | `instr_word` is being executed this cycle |
| done | output | 1 | Program ended on a return with no pending call |
| stack_err | output | 1 | Sticky return-stack overflow |

## Verification
The bench builds the block with its default parameters: a 1024-word store and an 8-entry stack. A self-calling word fills all eight slots within nine cycles, so the overflow path is reached directly. A run that starts at the last word reaches the address wrap. Random programs are confined to a 64-word window, which makes calls, nested returns and empty-stack returns frequent. These programs also use random values in the unused target bits, so any decoding of those bits would show up.

// File: rtl/shader_seq.sv
module shader_seq #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int DEPTH = 8,
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] OP_CALL = 6'h24,
  parameter logic [OPC_W-1:0] OP_RET = 6'h25,
  parameter logic [OPC_W-1:0] OP_FLUSH = 6'h23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] entry_pc,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] instr_word,
  output logic              instr_valid,
  output logic              done,
  output logic              stack_err
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DATA_W-1:0] EMPTY = '1;

  logic [DATA_W-1:0] prog [WORDS];
  logic [DATA_W-1:0] stk  [DEPTH];
  logic [ADDR_W-1:0] pc;
  logic [SP_W-1:0]   sp;
  logic              run, fin, err;

  always_ff @(posedge clk)
    if (wr_en) prog[wr_addr] <= wr_data;

  wire [DATA_W-1:0] iw      = prog[pc];
  wire [OPC_W-1:0]  op      = iw[DATA_W-1 -: OPC_W];
  wire [ADDR_W-1:0] tgt     = iw[ADDR_W-1:0];
  wire [SP_W-1:0]   sp_dec  = sp - SP_W'(1);
  wire [IDX_W-1:0]  top_idx = sp_dec[IDX_W-1:0];
  wire [IDX_W-1:0]  psh_idx = sp[IDX_W-1:0];
  wire [DATA_W-1:0] top     = (sp == '0) ? EMPTY : stk[top_idx];
  wire              is_call = run && (op == OP_CALL);
  wire              is_ret  = run && (op == OP_RET);
  wire              ovf     = is_call && (sp == SP_W'(DEPTH));
  wire              ret_end = is_ret && (top == EMPTY);

  assign fetch_addr  = pc;
  assign instr_word  = iw;
  assign instr_valid = run;
  assign done        = fin;
  assign stack_err   = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; sp <= '0; run <= 1'b0; fin <= 1'b0; err <= 1'b0;
    end else if (start) begin
      pc <= entry_pc; sp <= '0; run <= 1'b1; fin <= 1'b0;
    end else if (run) begin
      if (ovf) begin
        err <= 1'b1; run <= 1'b0;
      end else if (is_call) begin
        pc <= tgt; sp <= sp + SP_W'(1);
      end else if (ret_end) begin
        run <= 1'b0; fin <= 1'b1;
      end else if (is_ret) begin
        pc <= top[ADDR_W-1:0] + ADDR_W'(1); sp <= sp_dec;
      end else begin
        pc <= pc + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= EMPTY;
    end else if (start) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= EMPTY;
    end else if (is_call && !ovf) begin
      stk[psh_idx] <= DATA_W'(pc);
    end else if (is_ret && !ret_end) begin
      stk[top_idx] <= EMPTY;
    end
  end

  assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run && !fin && (pc == $past(entry_pc)) && (sp == '0));
  assert_call_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_call && !ovf && !start) |=> (pc == $past(tgt)) && (sp == $past(sp) + SP_W'(1)));
  assert_ret_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && !ret_end && !start) |=> pc == $past(top[ADDR_W-1:0]) + ADDR_W'(1));
  assert_ret_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_end && !start) |=> fin && !run);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_run_fin_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && fin));
endmodule

// File: tb/shader_seq_bench.sv
module shader_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_en = 1'b0;
  logic [9:0] entry_pc = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [9:0] fetch_addr;
  logic [31:0] instr_word;
  logic instr_valid, done, stack_err;
  int checks = 0, fails = 0;
  logic [31:0] bm [1024];

  localparam logic [5:0] OPC = 6'h24, OPR = 6'h25, OPF = 6'h23;

  shader_seq u_shader_seq (.clk, .rst_n, .start, .entry_pc, .wr_en, .wr_addr,
    .wr_data, .fetch_addr, .instr_word, .instr_valid, .done, .stack_err);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_call(input logic [9:0] t, input logic [15:0] junk);
    return {OPC, 10'(junk), junk[15:10], t};
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; bm[a] = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // Runs a program from e and compares every fetch with a bench model.
  // Returns 1 = ended on empty return, 2 = overflow, 0 = cycle limit.
  task automatic run_prog(input logic [9:0] e, input int maxc, output int how);
    logic [9:0] mpc, mstk [8];
    int msp;
    logic [5:0] op;
    how = 0;
    mpc = e; msp = 0;
    @(negedge clk); start = 1'b1; entry_pc = e;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R1 done cleared", 32'(done), 0);
    for (int c = 0; c < maxc && how == 0; c++) begin
      chk(instr_valid == 1'b1, "R1/R2 valid while running", 32'(instr_valid), 1);
      chk(fetch_addr == mpc, "R2/R3/R4 fetch address", 32'(fetch_addr), 32'(mpc));
      chk(instr_word == bm[mpc], "R8 instruction word", instr_word, bm[mpc]);
      op = bm[mpc][31:26];
      if (op == OPC) begin
        if (msp == 8) how = 2;
        else begin mstk[msp] = mpc; msp++; mpc = bm[mpc][9:0]; end
      end else if (op == OPR) begin
        if (msp == 0) how = 1;
        else begin msp--; mpc = mstk[msp] + 10'd1; end
      end else mpc = mpc + 10'd1;
      @(negedge clk);
    end
    if (how == 1) begin
      chk(done == 1'b1, "R5 done after empty return", 32'(done), 1);
      chk(instr_valid == 1'b0, "R5 fetch stops", 32'(instr_valid), 0);
    end else if (how == 2) begin
      chk(stack_err == 1'b1, "R7 overflow flag", 32'(stack_err), 1);
      chk(instr_valid == 1'b0, "R7 fetch halts", 32'(instr_valid), 0);
      chk(done == 1'b0, "R7 no done on overflow", 32'(done), 0);
    end
  endtask

  initial begin
    int how;
    logic [9:0] base;
    int r;
    void'($urandom(32'd4242));
    @(negedge clk);
    chk(instr_valid == 1'b0 && done == 1'b0 && stack_err == 1'b0, "R9 reset outputs",
        {29'd0, instr_valid, done, stack_err}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 1024; a++) wr(10'(a), 32'h0000_0000);

    // Nested calls with flush and a plain word
    wr(10'd5, 32'h0800_1234);
    wr(10'd6, mk_call(10'd20, 16'hfc00));
    wr(10'd7, {OPR, 26'd0});
    wr(10'd20, {OPF, 26'h155});
    wr(10'd21, mk_call(10'd40, 16'h0000));
    wr(10'd22, {OPR, 26'h3});
    wr(10'd40, {OPR, 26'h0});
    run_prog(10'd5, 50, how);
    chk(how == 1, "R3/R4/R6 nested program ends", 32'(how), 1);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R5 done held while idle", 32'(done), 1);

    // Wrap from the last word
    wr(10'd1023, 32'h0400_0000);
    wr(10'd0, {OPR, 26'd0});
    run_prog(10'd1023, 10, how);
    chk(how == 1, "R2 wrap then end", 32'(how), 1);

    // Rewrite a word and rerun: new content must appear (R8)
    wr(10'd5, {OPR, 26'h2aa});
    run_prog(10'd5, 10, how);
    chk(how == 1, "R8 rewritten word executes", 32'(how), 1);

    // Self call: eight pushes succeed, the ninth overflows
    wr(10'd100, mk_call(10'd100, 16'h3c00));
    run_prog(10'd100, 20, how);
    chk(how == 2, "R7 overflow on ninth call", 32'(how), 2);
    repeat (2) @(negedge clk);
    chk(stack_err == 1'b1, "R7 flag sticky", 32'(stack_err), 1);
    pulse_reset();
    chk(stack_err == 1'b0 && done == 1'b0, "R9 reset clears flags", {30'd0, stack_err, done}, 0);
    wr(10'd100, 32'h0);

    // Random programs in a 64-word window
    for (int it = 0; it < 12; it++) begin
      base = 10'(($urandom % 15) * 64);
      for (int k = 0; k < 64; k++) begin
        r = $urandom % 100;
        if (r < 15) wr(base + 10'(k), mk_call(base + 10'($urandom % 64), 16'($urandom)));
        else if (r < 40) wr(base + 10'(k), {OPR, 26'($urandom)});
        else if (r < 45) wr(base + 10'(k), {OPF, 26'($urandom)});
        else wr(base + 10'(k), {6'($urandom % 32), 26'($urandom)});
      end
      run_prog(base + 10'($urandom % 64), 300, how);
      if (how != 1) pulse_reset();
      for (int k = 0; k < 64; k++) wr(base + 10'(k), 32'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule